// File: doc/BRIEF.md
# UDP Transmit Framer with Payload Buffer

The block gathers a user payload of 64-bit words in a ring buffer and, once the user commits the frame, sends it as one Ethernet/IPv4/UDP frame on a 64-bit byte-lane stream. The Ethernet destination is the broadcast address. The source MAC, the source IP and the source UDP port come from configuration inputs. The destination IP and the destination UDP port come from the user side in the commit cycle. The block fills in both length fields and computes the IPv4 header checksum. It then shifts the payload by the 42-byte header offset, so each payload word straddles two output beats.

The write side uses a valid/ack pair. A word counts as taken only in a cycle where `wr_ack` is high alongside `wr_valid`. A word presented while `wr_ack` is low is not stored, and the user may keep presenting it to retry. The output side is valid/ready. A beat is held unchanged while `out_tready` is low, and it advances only on a cycle where valid and ready are both high.

A committed frame keeps its buffer space until its last beat is accepted. While it is being sent, new payload words may fill the remaining space. A further commit is held off until the frame in flight has finished.

Top module: `udp_tx_framer`

## Requirements
- R1: While the buffer is not full, a word presented with `wr_valid` high and `wr_drop` low is stored, and `wr_ack` is high in that same cycle. A word that ends a frame also needs no frame in flight. Words are sent in the order they were acknowledged.
- R2: The buffer holds 2^BUF_AW words, counting both uncommitted words and the words of the frame in flight. When it is full, `wr_ack` stays low and the presented word is not stored.
- R3: An acknowledged word with `wr_last` high commits the frame. That word is the frame's last payload word, and the frame's word count N includes it. Each payload word goes out most significant byte first, starting at stream byte 42.
- R4: When `wr_drop` is high, every uncommitted word is discarded, and so is the word presented in that cycle (`wr_ack` low). A frame already in flight is not affected.
- R5: The destination IP and port, the source MAC, IP and port, and N are all taken in the commit cycle. Values on those inputs in any other cycle have no effect on the frame.
- R6: While a frame is in flight (`out_tvalid` high), a word with `wr_last` high gets no ack, including in the cycle where the final beat is accepted. Words without `wr_last` are still accepted if there is room.
- R7: Stream byte k travels in beat k/8, in `out_tdata` bits [8*(k%8)+7 : 8*(k%8)]. Bytes 0-5 are ff, bytes 6-11 are the source MAC (most significant byte first), and bytes 12-13 are 08 00.
- R8: Bytes 14-33 are an IPv4 header with these fields:
  - version/IHL 0x45, then TOS 0;
  - total length 28+8N;
  - identification 0 and flags/fragment 0;
  - TTL 0x40 and protocol 0x11;
  - the header checksum, which is the ones' complement of the folded ones'-complement sum of the ten 16-bit header words;
  - the source IP, then the destination IP.
- R9: Bytes 34-41 are the UDP header: the source port, the destination port, the length 8+8N and a checksum of 0.
- R10: A frame has N+6 beats. `out_tkeep` is 0xFF on every beat but the last. The last beat carries `out_tlast` and `out_tkeep` = 0x03.
- R11: The first beat is valid in the cycle after the commit. While `out_tvalid` is high and `out_tready` is low, the beat and its tkeep and tlast stay stable.
- R12: `tx_activity` is high for exactly one cycle, the cycle after the last beat of a frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src_mac | input | 48 | Source MAC address |
| cfg_src_ip | input | 32 | Source IPv4 address |
| cfg_src_port | input | 16 | Source UDP port (listen port) |
| wr_data | input | 64 | Payload word |
| wr_valid | input | 1 | Payload word present |
| wr_last | input | 1 | Word ends the frame (commit) |
| wr_drop | input | 1 | Discard the uncommitted words |
| wr_ack | output | 1 | Presented word stored this cycle |
| dst_ip | input | 32 | Destination IPv4 address, used at commit |
| dst_port | input | 16 | Destination UDP port, used at commit |
| out_tdata | output | 64 | Frame bytes, byte 0 in the low lane |
| out_tkeep | output | 8 | Valid byte lanes |
| out_tlast | output | 1 | Final beat of the frame |
| out_tvalid | output | 1 | Beat valid |
| out_tready | input | 1 | Sink accepts the beat |
| tx_activity | output | 1 | One-cycle pulse per frame sent |

## Verification
The bench builds the block with BUF_AW = 4, which gives a 16-word ring. With that size, a full buffer, a commit refused for lack of room, and the mix of an in-flight frame and fresh words that exhausts the space are all reached within a few dozen cycles. Because the ring is small, the read and write pointers also wrap many times over the run, so the payload-address arithmetic across the wrap is exercised. The default of 11 gives 2048 words and is not what the bench runs.

// File: rtl/udp_tx_pkg.sv
package udp_tx_pkg;
  localparam int WORD_W         = 64;
  localparam int LANES          = WORD_W / 8;
  localparam int HDR_BYTES      = 42;
  localparam int HDR_BITS       = HDR_BYTES * 8;
  localparam int HDR_FULL_BEATS = HDR_BYTES / LANES;   // 5 beats of pure header

  // network byte order (first byte in bits 63:56) to lane order (first byte in lane 0)
  function automatic logic [WORD_W-1:0] to_lanes(input logic [WORD_W-1:0] be);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[8*i +: 8] = be[WORD_W-1-8*i -: 8];
    return r;
  endfunction
endpackage

// File: rtl/udp_tx_buf.sv
module udp_tx_buf #(
  parameter int DATA_W = 64,
  parameter int AW     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              in_drop,
  input  logic              snd_busy,
  input  logic              snd_rel,
  output logic              in_ack,
  output logic              commit,
  output logic [AW-1:0]     commit_base,
  output logic [AW:0]       commit_len,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0] wr_ptr, base_ptr, rd_ptr, fl_end, fill;
  logic        room;

  assign fill        = wr_ptr - rd_ptr;
  assign room        = ~fill[AW];
  assign in_ack      = in_valid & ~in_drop & room & ~(in_last & snd_busy);
  assign commit      = in_ack & in_last;
  assign commit_base = base_ptr[AW-1:0];
  assign commit_len  = wr_ptr - base_ptr + (AW+1)'(1);
  assign rd_word     = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (in_ack) mem[wr_ptr[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      base_ptr <= '0;
      rd_ptr   <= '0;
      fl_end   <= '0;
    end else begin
      if (in_drop)     wr_ptr <= base_ptr;
      else if (in_ack) wr_ptr <= wr_ptr + (AW+1)'(1);
      if (commit) begin
        base_ptr <= wr_ptr + (AW+1)'(1);
        fl_end   <= wr_ptr + (AW+1)'(1);
      end
      if (snd_rel) rd_ptr <= fl_end;
    end
  end
endmodule

// File: rtl/udp_tx_hdr.sv
module udp_tx_hdr import udp_tx_pkg::*; #(
  parameter int LEN_W = 12
) (
  input  logic [47:0]         src_mac,
  input  logic [31:0]         src_ip,
  input  logic [15:0]         src_port,
  input  logic [31:0]         dst_ip,
  input  logic [15:0]         dst_port,
  input  logic [LEN_W-1:0]    len_words,
  output logic [HDR_BITS-1:0] hdr
);
  logic [15:0] pay_bytes, ip_total, udp_len, csum;
  logic [31:0] sum;
  logic [16:0] fold1;
  logic [15:0] fold2;

  always_comb begin
    pay_bytes = 16'(len_words) << 3;
    ip_total  = pay_bytes + 16'd28;
    udp_len   = pay_bytes + 16'd8;
    sum = 32'h4500 + 32'(ip_total) + 32'h4011
        + 32'(src_ip[31:16]) + 32'(src_ip[15:0])
        + 32'(dst_ip[31:16]) + 32'(dst_ip[15:0]);
    fold1 = 17'(sum[15:0]) + 17'(sum[31:16]);
    fold2 = fold1[15:0] + 16'(fold1[16]);
    csum  = ~fold2;
    hdr = {48'hFFFF_FFFF_FFFF, src_mac, 16'h0800,
           8'h45, 8'h00, ip_total, 16'h0000, 16'h0000, 8'h40, 8'h11, csum,
           src_ip, dst_ip,
           src_port, dst_port, udp_len, 16'h0000};
  end
endmodule

// File: rtl/udp_tx_emit.sv
module udp_tx_emit import udp_tx_pkg::*; #(
  parameter int AW = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit,
  input  logic [AW-1:0]       commit_base,
  input  logic [AW:0]         commit_len,
  input  logic [HDR_BITS-1:0] hdr_in,
  input  logic [WORD_W-1:0]   rd_word,
  output logic [AW-1:0]       rd_addr,
  output logic [WORD_W-1:0]   out_tdata,
  output logic [LANES-1:0]    out_tkeep,
  output logic                out_tlast,
  output logic                out_tvalid,
  input  logic                out_tready,
  output logic                busy,
  output logic                rel,
  output logic                activity
);
  localparam int BW = AW + 2;

  logic [BW-1:0]       beat, last_idx;
  logic [AW-1:0]       base_q;
  logic [AW:0]         len_q;
  logic [HDR_BITS-1:0] hdr_q;
  logic [15:0]         carry_q, hi16;
  logic [WORD_W-1:0]   be;
  logic                is_last, accept, act_q;

  assign last_idx   = BW'(len_q) + BW'(HDR_FULL_BEATS);
  assign is_last    = (beat == last_idx);
  assign accept     = busy & out_tready;
  assign rel        = accept & is_last;
  assign rd_addr    = base_q + AW'(beat - BW'(HDR_FULL_BEATS));
  assign out_tvalid = busy;
  assign out_tlast  = busy & is_last;
  assign out_tkeep  = is_last ? LANES'(8'h03) : {LANES{1'b1}};
  assign out_tdata  = to_lanes(be);
  assign activity   = act_q;

  always_comb begin
    be   = '0;
    hi16 = (beat == BW'(HDR_FULL_BEATS)) ? hdr_q[15:0] : carry_q;
    if (beat < BW'(HDR_FULL_BEATS)) begin
      for (int k = 0; k < HDR_FULL_BEATS; k++)
        if (beat == BW'(k)) be = hdr_q[HDR_BITS-1-WORD_W*k -: WORD_W];
    end else begin
      be = {hi16, is_last ? 48'h0 : rd_word[WORD_W-1:16]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      beat    <= '0;
      base_q  <= '0;
      len_q   <= '0;
      hdr_q   <= '0;
      carry_q <= '0;
      act_q   <= 1'b0;
    end else begin
      act_q <= rel;
      if (commit) begin
        busy   <= 1'b1;
        beat   <= '0;
        base_q <= commit_base;
        len_q  <= commit_len;
        hdr_q  <= hdr_in;
      end else if (accept) begin
        if (is_last) busy <= 1'b0;
        else         beat <= beat + BW'(1);
        if (beat >= BW'(HDR_FULL_BEATS) && !is_last) carry_q <= rd_word[15:0];
      end
    end
  end
endmodule

// File: rtl/udp_tx_framer.sv
module udp_tx_framer import udp_tx_pkg::*; #(
  parameter int BUF_AW = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [47:0]        cfg_src_mac,
  input  logic [31:0]        cfg_src_ip,
  input  logic [15:0]        cfg_src_port,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               wr_valid,
  input  logic               wr_last,
  input  logic               wr_drop,
  output logic               wr_ack,
  input  logic [31:0]        dst_ip,
  input  logic [15:0]        dst_port,
  output logic [WORD_W-1:0]  out_tdata,
  output logic [LANES-1:0]   out_tkeep,
  output logic               out_tlast,
  output logic               out_tvalid,
  input  logic               out_tready,
  output logic               tx_activity
);
  logic                commit, snd_busy, snd_rel;
  logic [BUF_AW-1:0]   commit_base, rd_addr;
  logic [BUF_AW:0]     commit_len;
  logic [WORD_W-1:0]   rd_word;
  logic [HDR_BITS-1:0] hdr;

  udp_tx_buf #(.DATA_W(WORD_W), .AW(BUF_AW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .in_data(wr_data), .in_valid(wr_valid), .in_last(wr_last), .in_drop(wr_drop),
    .snd_busy(snd_busy), .snd_rel(snd_rel),
    .in_ack(wr_ack), .commit(commit), .commit_base(commit_base), .commit_len(commit_len),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  udp_tx_hdr #(.LEN_W(BUF_AW + 1)) u_hdr (
    .src_mac(cfg_src_mac), .src_ip(cfg_src_ip), .src_port(cfg_src_port),
    .dst_ip(dst_ip), .dst_port(dst_port), .len_words(commit_len), .hdr(hdr)
  );

  udp_tx_emit #(.AW(BUF_AW)) u_emit (
    .clk(clk), .rst_n(rst_n),
    .commit(commit), .commit_base(commit_base), .commit_len(commit_len), .hdr_in(hdr),
    .rd_word(rd_word), .rd_addr(rd_addr),
    .out_tdata(out_tdata), .out_tkeep(out_tkeep), .out_tlast(out_tlast),
    .out_tvalid(out_tvalid), .out_tready(out_tready),
    .busy(snd_busy), .rel(snd_rel), .activity(tx_activity)
  );
endmodule

// File: rtl/udp_tx_framer_chk.sv
module udp_tx_framer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic        wr_last,
  input logic        wr_drop,
  input logic        wr_ack,
  input logic [63:0] out_tdata,
  input logic [7:0]  out_tkeep,
  input logic        out_tlast,
  input logic        out_tvalid,
  input logic        out_tready,
  input logic        tx_activity
);
  // R11
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tvalid && !out_tready |=> out_tvalid && $stable(out_tdata) && $stable(out_tkeep) && $stable(out_tlast));
  // R10
  last_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tvalid && out_tlast |-> out_tkeep == 8'h03);
  // R10
  body_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tvalid && !out_tlast |-> out_tkeep == 8'hFF);
  // R12
  act_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_activity |-> $past(out_tvalid && out_tready && out_tlast));
  // R12
  act_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_activity |=> !tx_activity);
  // R4
  drop_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |-> !wr_ack);
  // R6
  busy_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tvalid && wr_valid && wr_last |-> !wr_ack);
  // R3
  commit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ack && wr_last |=> out_tvalid && !out_tlast);
endmodule

bind udp_tx_framer udp_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_last(wr_last), .wr_drop(wr_drop),
  .wr_ack(wr_ack), .out_tdata(out_tdata), .out_tkeep(out_tkeep), .out_tlast(out_tlast),
  .out_tvalid(out_tvalid), .out_tready(out_tready), .tx_activity(tx_activity)
);

// File: tb/udp_tx_framer_bench.sv
module udp_tx_framer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam logic [47:0] SMAC  = 48'h02_1A_2B_3C_4D_5E;
  localparam logic [31:0] SIP   = 32'hC0A8_010A;
  localparam logic [15:0] SPORT = 16'hC350;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [63:0] wr_data = '0;
  logic        wr_valid = 1'b0, wr_last = 1'b0, wr_drop = 1'b0, out_tready = 1'b0;
  logic [31:0] dst_ip = '0;
  logic [15:0] dst_port = '0;
  logic        wr_ack, out_tlast, out_tvalid, tx_activity;
  logic [63:0] out_tdata;
  logic [7:0]  out_tkeep;

  always #(CLK_PERIOD/2) clk = ~clk;

  udp_tx_framer #(.BUF_AW(AW)) u_udp_tx_framer (
    .clk(clk), .rst_n(rst_n),
    .cfg_src_mac(SMAC), .cfg_src_ip(SIP), .cfg_src_port(SPORT),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_last(wr_last), .wr_drop(wr_drop), .wr_ack(wr_ack),
    .dst_ip(dst_ip), .dst_port(dst_port),
    .out_tdata(out_tdata), .out_tkeep(out_tkeep), .out_tlast(out_tlast),
    .out_tvalid(out_tvalid), .out_tready(out_tready), .tx_activity(tx_activity)
  );

  typedef struct { logic [63:0] d; logic [7:0] k; logic l; int idx; } beat_t;

  int checks = 0, errors = 0, cyc = 0, inflight = 0;
  logic [63:0] pend[$];
  beat_t       expq[$];
  logic        exp_act = 1'b0;
  logic [63:0] word_ctr = 64'h1111_0000_0000_0001;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic string beat_tag(input int idx);
    if (idx == 0) return "R7";
    if (idx <= 2) return "R8";
    if (idx == 3) return "R5";
    if (idx == 4) return "R9";
    return "R3";
  endfunction

  // R7 R8 R9 R10: expected beats from the byte layout of the requirements
  task automatic build_frame(input logic [31:0] dip, input logic [15:0] dport);
    logic [7:0] q[$];
    int n, tot, ul, sum, bi;
    logic [15:0] cs;
    n = pend.size(); tot = 28 + 8*n; ul = 8 + 8*n;
    for (int i = 0; i < 6; i++) q.push_back(8'hFF);
    for (int i = 5; i >= 0; i--) q.push_back(SMAC[8*i +: 8]);
    q.push_back(8'h08); q.push_back(8'h00);
    q.push_back(8'h45); q.push_back(8'h00);
    q.push_back(tot[15:8]); q.push_back(tot[7:0]);
    for (int i = 0; i < 4; i++) q.push_back(8'h00);
    q.push_back(8'h40); q.push_back(8'h11);
    q.push_back(8'h00); q.push_back(8'h00);
    for (int i = 3; i >= 0; i--) q.push_back(SIP[8*i +: 8]);
    for (int i = 3; i >= 0; i--) q.push_back(dip[8*i +: 8]);
    sum = 0;
    for (int i = 14; i < 34; i += 2) sum += {16'h0, q[i], q[i+1]};
    while (sum > 32'hFFFF) sum = (sum & 32'hFFFF) + (sum >> 16);
    cs = ~sum[15:0];
    q[24] = cs[15:8]; q[25] = cs[7:0];
    q.push_back(SPORT[15:8]); q.push_back(SPORT[7:0]);
    q.push_back(dport[15:8]); q.push_back(dport[7:0]);
    q.push_back(ul[15:8]); q.push_back(ul[7:0]);
    q.push_back(8'h00); q.push_back(8'h00);
    foreach (pend[w]) for (int i = 7; i >= 0; i--) q.push_back(pend[w][8*i +: 8]);
    bi = 0;
    for (int b = 0; b < q.size(); b += 8) begin
      beat_t e;
      e.d = '0; e.k = '0; e.idx = bi;
      for (int j = 0; j < 8; j++)
        if (b + j < q.size()) begin e.d[8*j +: 8] = q[b+j]; e.k[j] = 1'b1; end
      e.l = (b + 8 >= q.size());
      expq.push_back(e);
      bi++;
    end
  endtask

  task automatic step(input logic v, input logic l, input logic drp, input logic rdy);
    logic busy_m, exp_ack;
    logic [63:0] m;
    int fill;
    string tg;
    @(negedge clk);
    wr_valid = v; wr_data = word_ctr; wr_last = l; wr_drop = drp; out_tready = rdy;
    dst_ip = 32'h0A00_0000 + 32'(cyc * 7); dst_port = 16'hC000 + 16'(cyc);
    #(CLK_PERIOD/2 - 1);
    busy_m = (expq.size() != 0);
    fill = pend.size() + inflight;
    exp_ack = v && !drp && (fill < DEPTH) && !(l && busy_m);
    if (drp) tg = "R4";
    else if (fill >= DEPTH) tg = "R2";
    else if (l && busy_m) tg = "R6";
    else tg = "R1";
    chk(wr_ack === exp_ack, tg, 64'(wr_ack), 64'(exp_ack));
    chk(out_tvalid === busy_m, "R11", 64'(out_tvalid), 64'(busy_m));
    chk(tx_activity === exp_act, "R12", 64'(tx_activity), 64'(exp_act));
    if (busy_m && out_tvalid) begin
      for (int j = 0; j < 8; j++) m[8*j +: 8] = {8{expq[0].k[j]}};
      chk((out_tdata & m) === expq[0].d, beat_tag(expq[0].idx), out_tdata & m, expq[0].d);
      chk(out_tkeep === expq[0].k, "R10", 64'(out_tkeep), 64'(expq[0].k));
      chk(out_tlast === expq[0].l, "R10", 64'(out_tlast), 64'(expq[0].l));
    end
    exp_act = 1'b0;
    if (busy_m && rdy) begin
      if (expq[0].l) begin inflight = 0; exp_act = 1'b1; end
      void'(expq.pop_front());
    end
    if (drp) pend.delete();
    else if (exp_ack) begin
      pend.push_back(word_ctr);
      if (l) begin
        build_frame(dst_ip, dst_port);
        inflight = pend.size();
        pend.delete();
      end
    end
    if (exp_ack) word_ctr = word_ctr + 64'h0101_0203_0507_0B0D;
    cyc++;
  endtask

  task automatic idle(input int n, input logic rdy);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, rdy);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R11 R12 R1)
    chk(out_tvalid === 1'b0, "R11", 64'(out_tvalid), 64'd0);
    chk(tx_activity === 1'b0, "R12", 64'(tx_activity), 64'd0);
    chk(wr_ack === 1'b0, "R1", 64'(wr_ack), 64'd0);
    rst_n = 1'b1;
    idle(2, 1'b1);

    // single-word frame, sink always ready
    step(1, 1, 0, 1);
    idle(10, 1'b1);

    // three-word frame, sink stalls every third cycle
    step(1, 0, 0, 1); step(1, 0, 0, 1); step(1, 1, 0, 1);
    for (int i = 0; i < 15; i++) step(0, 0, 0, (i % 3) != 0);

    // drop mid-frame, including a word presented with the drop
    step(1, 0, 0, 1); step(1, 0, 0, 1); step(1, 0, 1, 1);
    step(1, 0, 0, 1); step(1, 1, 0, 1);
    idle(12, 1'b1);

    // fill to full, commit refused for lack of room, then drop
    for (int i = 0; i < 18; i++) step(1, 0, 0, 0);
    step(1, 1, 0, 0);
    step(0, 0, 1, 0);
    // frame of 10 held by a stalled sink; extra words until full
    for (int i = 0; i < 9; i++) step(1, 0, 0, 0);
    step(1, 1, 0, 0);
    for (int i = 0; i < 7; i++) step(1, 0, 0, 0);
    step(1, 1, 0, 0);
    // commit retried every cycle while the sink drains
    for (int i = 0; i < 40; i++) step(1, 1, 0, 1);
    idle(30, 1'b1);

    // frames of rising length with a pseudo-random sink, pointers wrap
    for (int f = 0; f < 8; f++) begin
      for (int w = 0; w < 3 + f; w++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(1, w == 2 + f, 0, lf[0] | lf[3]);
      end
    end
    idle(80, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule